// File: doc/BRIEF.md
# Stream-to-Buffer Write Channel with Status Records

This block takes packets from an AXI4-Stream slave port and writes them into a queue of destination buffers. Each buffer is described by a destination base address, a buffer length in bytes and a status address. Buffers are used strictly in the order they were queued. A packet larger than its buffer continues into the next queued buffer. Every accepted beat becomes one memory write request carrying an address, data and byte strobes.

A buffer is closed when it is full or when a beat with tlast is accepted. On close, the block issues a two-word status record to that buffer's status address. The record holds a fixed validity code, an end-of-packet flag and the number of bytes placed in the buffer. Buffer descriptors enter on a valid/ready input and write requests leave on a valid/ready output. A channel enable gates data acceptance. Malformed descriptors are rejected and flagged, and the channel then halts until the enable is cycled.

Top module: `s2d_wr_chan`

## Requirements
- R1: s_tready_o is high only when enable_i is high, no error flag is set, at least one accepted descriptor is queued, and the block is not emitting a status record.
- R2: Buffers are filled in queue order. The k-th beat (k from 0) into a buffer is written at base + k*DWB. A packet that overflows a buffer continues at the base of the next queued buffer.
- R3: A buffer closes on the beat that fills it or on a tlast beat, whichever comes first. A tlast beat that exactly fills the buffer produces a single status record, and no empty record follows it.
- R4: After the closing beat's data write, two status writes follow, each carrying data in bits 31:0 with strobe 0x0F. Word 0 goes to the status address and holds 16'h52b4 in bits 31:16, zeros in bits 15:1 and the end-of-packet flag in bit 0. Word 1 goes to the status address + 4 and holds the byte count.
- R5: The end-of-packet flag is 1 only when the buffer was closed by a tlast beat. It is 0 when the buffer filled in the middle of a packet.
- R6: The byte count equals DWB times the number of full beats, plus the number of set tkeep bits on a tlast beat. A data write's strobe is tkeep on a tlast beat and all ones otherwise.
- R7: A descriptor whose length is zero or not a multiple of 64 is consumed and dropped, and err_len_o is set.
- R8: A descriptor whose status address has bits 11:0 above 0xFF8 is consumed and dropped, and err_wb_o is set. A value of exactly 0xFF8 is accepted.
- R9: While either error flag is set, s_tready_o stays low. Both flags clear on the first clock after enable_i rises.
- R10: While wr_valid_o is high and wr_ready_i is low, the write request (address, data and strobe) holds stable.
- R11: After reset, s_tready_o, wr_valid_o, err_len_o and err_wb_o are low and desc_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Channel enable |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Descriptor queue has room |
| desc_dst_i | input | AW | Buffer base address |
| desc_len_i | input | LW | Buffer length in bytes |
| desc_wb_i | input | AW | Status record address |
| s_tvalid_i | input | 1 | Stream beat valid |
| s_tready_o | output | 1 | Stream beat accepted |
| s_tdata_i | input | 8*DWB | Stream data |
| s_tkeep_i | input | DWB | Stream byte enables, packed to the LSB |
| s_tlast_i | input | 1 | Last beat of a packet |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request taken |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | 8*DWB | Write data |
| wr_strb_o | output | DWB | Write byte strobes |
| err_len_o | output | 1 | Bad buffer length seen |
| err_wb_o | output | 1 | Status address crosses a 4 KB page |

## Verification
A wrong byte counter shows up as a misplaced data address within one beat, and as a wrong count in status word 1 when the buffer closes. A close-decision fault appears as a status record emitted after the wrong data write, as a missing record, or as an extra empty record. These are visible in the ordered write list within a few cycles of the offending beat. A stuck error or enable state shows at once as tready staying low with data and a descriptor present, or as tready rising during a halt. Backpressure on the write port checks that a held request never changes and that no write is lost or duplicated.

// File: rtl/s2d_pkg.sv
package s2d_pkg;
  typedef enum logic [1:0] {PH_DATA, PH_REC0, PH_REC1} phase_e;
  localparam logic [15:0] REC_MAGIC = 16'h52b4;
endpackage

// File: rtl/s2d_desc_fifo.sv
module s2d_desc_fifo #(
  parameter int W     = 160,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;

  assign full_o  = (cnt_q == (PW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= data_i;
  end
endmodule

// File: rtl/s2d_desc_check.sv
module s2d_desc_check #(
  parameter int LW = 32
) (
  input  logic [LW-1:0] len_i,
  input  logic [11:0]   wb_lo_i,
  output logic          len_ok_o,
  output logic          wb_ok_o
);
  // 8-byte record must stay inside one 4 KB page
  assign len_ok_o = (len_i != '0) && (len_i[5:0] == 6'd0);
  assign wb_ok_o  = (wb_lo_i <= 12'hFF8);
endmodule

// File: rtl/s2d_keep_count.sv
module s2d_keep_count #(
  parameter int DWB = 8,
  localparam int KW = $clog2(DWB) + 1
) (
  input  logic [DWB-1:0] keep_i,
  output logic [KW-1:0]  cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < DWB; i++) cnt_o = cnt_o + KW'(keep_i[i]);
  end
endmodule

// File: rtl/s2d_wr_chan.sv
module s2d_wr_chan #(
  parameter int AW     = 64,
  parameter int LW     = 32,
  parameter int DWB    = 8,
  parameter int QDEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             desc_valid_i,
  output logic             desc_ready_o,
  input  logic [AW-1:0]    desc_dst_i,
  input  logic [LW-1:0]    desc_len_i,
  input  logic [AW-1:0]    desc_wb_i,
  input  logic             s_tvalid_i,
  output logic             s_tready_o,
  input  logic [8*DWB-1:0] s_tdata_i,
  input  logic [DWB-1:0]   s_tkeep_i,
  input  logic             s_tlast_i,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic [AW-1:0]    wr_addr_o,
  output logic [8*DWB-1:0] wr_data_o,
  output logic [DWB-1:0]   wr_strb_o,
  output logic             err_len_o,
  output logic             err_wb_o
);
  import s2d_pkg::*;

  localparam int DATA_W = 8 * DWB;
  localparam int KW     = $clog2(DWB) + 1;
  localparam int DESC_W = 2 * AW + LW;

  // descriptor intake
  logic len_ok, wb_ok, q_full, q_empty, q_push, q_pop;
  logic [DESC_W-1:0] q_head;
  logic [AW-1:0] cur_dst, cur_wb;
  logic [LW-1:0] cur_len;

  s2d_desc_check #(.LW(LW)) u_check (
    .len_i   (desc_len_i),
    .wb_lo_i (desc_wb_i[11:0]),
    .len_ok_o(len_ok),
    .wb_ok_o (wb_ok)
  );

  assign desc_ready_o = !q_full;
  assign q_push = desc_valid_i && desc_ready_o && len_ok && wb_ok;

  s2d_desc_fifo #(.W(DESC_W), .DEPTH(QDEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (q_push),
    .data_i ({desc_wb_i, desc_len_i, desc_dst_i}),
    .pop_i  (q_pop),
    .data_o (q_head),
    .full_o (q_full),
    .empty_o(q_empty)
  );

  assign {cur_wb, cur_len, cur_dst} = q_head;

  // error flags, cleared on enable rising
  logic en_q, err_len_q, err_wb_q, halt;
  wire  desc_hs = desc_valid_i && desc_ready_o;
  wire  en_rise = enable_i && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      err_len_q <= 1'b0;
      err_wb_q  <= 1'b0;
    end else begin
      en_q <= enable_i;
      if (desc_hs && !len_ok) err_len_q <= 1'b1;
      else if (en_rise)       err_len_q <= 1'b0;
      if (desc_hs && !wb_ok)  err_wb_q  <= 1'b1;
      else if (en_rise)       err_wb_q  <= 1'b0;
    end
  end

  assign halt      = err_len_q || err_wb_q;
  assign err_len_o = err_len_q;
  assign err_wb_o  = err_wb_q;

  // data path
  phase_e phase_q;
  logic [LW-1:0] cnt_q, rec_len_q, cnt_next, beat_bytes;
  logic rec_eop_q, rec0_q;
  logic [KW-1:0] keep_cnt;
  logic wr_valid_q;
  logic [AW-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic [DWB-1:0] wr_strb_q;
  logic out_free, beat, fill, close_buf;

  s2d_keep_count #(.DWB(DWB)) u_keep (
    .keep_i(s_tkeep_i),
    .cnt_o (keep_cnt)
  );

  assign out_free   = !wr_valid_q || wr_ready_i;
  assign s_tready_o = enable_i && !halt && !q_empty && (phase_q == PH_DATA) && out_free;
  assign beat       = s_tvalid_i && s_tready_o;
  assign beat_bytes = s_tlast_i ? LW'(keep_cnt) : LW'(DWB);
  assign cnt_next   = cnt_q + beat_bytes;
  assign fill       = (cnt_q + LW'(DWB)) >= cur_len;
  assign close_buf  = s_tlast_i || fill;
  assign q_pop      = (phase_q == PH_REC1) && out_free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_DATA;
      cnt_q      <= '0;
      rec_len_q  <= '0;
      rec_eop_q  <= 1'b0;
      rec0_q     <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      wr_strb_q  <= '0;
    end else if (beat) begin
      wr_valid_q <= 1'b1;
      wr_addr_q  <= cur_dst + AW'(cnt_q);
      wr_data_q  <= s_tdata_i;
      wr_strb_q  <= s_tlast_i ? s_tkeep_i : '1;
      rec0_q     <= 1'b0;
      if (close_buf) begin
        phase_q   <= PH_REC0;
        rec_len_q <= cnt_next;
        rec_eop_q <= s_tlast_i;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_next;
      end
    end else if (phase_q == PH_REC0 && out_free) begin
      wr_valid_q <= 1'b1;
      wr_addr_q  <= cur_wb;
      wr_data_q  <= DATA_W'({REC_MAGIC, 15'd0, rec_eop_q});
      wr_strb_q  <= DWB'(4'hF);
      rec0_q     <= 1'b1;
      phase_q    <= PH_REC1;
    end else if (phase_q == PH_REC1 && out_free) begin
      wr_valid_q <= 1'b1;
      wr_addr_q  <= cur_wb + AW'(4);
      wr_data_q  <= DATA_W'(rec_len_q);
      wr_strb_q  <= DWB'(4'hF);
      rec0_q     <= 1'b0;
      phase_q    <= PH_DATA;
    end else if (wr_ready_i) begin
      wr_valid_q <= 1'b0;
      rec0_q     <= 1'b0;
    end
  end

  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign wr_strb_o  = wr_strb_q;
endmodule

// File: rtl/s2d_wr_chan_chk.sv
module s2d_wr_chan_chk #(
  parameter int AW  = 64,
  parameter int DWB = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             desc_valid_i,
  input logic             desc_ready_o,
  input logic             s_tready_o,
  input logic             wr_valid_o,
  input logic             wr_ready_i,
  input logic [AW-1:0]    wr_addr_o,
  input logic [8*DWB-1:0] wr_data_o,
  input logic [DWB-1:0]   wr_strb_o,
  input logic             err_len_o,
  input logic             err_wb_o,
  input logic             rec0_q
);
  a_r1_ready_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_tready_o |-> enable_i);

  a_r9_halt_blocks_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_len_o || err_wb_o) |-> !s_tready_o);

  a_r10_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o)
                                     && $stable(wr_data_o) && $stable(wr_strb_o)));

  a_r4_record_word0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && rec0_q) |-> (wr_data_o[31:16] == 16'h52b4 && wr_data_o[15:1] == 15'd0
                                && wr_strb_o == DWB'(4'hF)));

  a_r7_err_from_desc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_len_o) |-> $past(desc_valid_i && desc_ready_o));

  a_r8_err_from_desc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_wb_o) |-> $past(desc_valid_i && desc_ready_o));
endmodule

bind s2d_wr_chan s2d_wr_chan_chk #(.AW(AW), .DWB(DWB)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .desc_valid_i(desc_valid_i),
  .desc_ready_o(desc_ready_o),
  .s_tready_o  (s_tready_o),
  .wr_valid_o  (wr_valid_o),
  .wr_ready_i  (wr_ready_i),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .wr_strb_o   (wr_strb_o),
  .err_len_o   (err_len_o),
  .err_wb_o    (err_wb_o),
  .rec0_q      (rec0_q)
);

// File: tb/s2d_wr_chan_tb.sv
module s2d_wr_chan_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic dv = 1'b0, dr;
  logic [63:0] d_dst = '0, d_wb = '0;
  logic [31:0] d_len = '0;
  logic tv = 1'b0, tr, tl = 1'b0;
  logic [63:0] td = '0;
  logic [7:0]  tk = '0;
  logic wv, wrdy = 1'b1;
  logic [63:0] wa, wd;
  logic [7:0]  ws;
  logic el, ew;

  int checks = 0, errors = 0, beat_id = 0;
  bit done = 0;

  logic [63:0] got_a[$], got_d[$], exp_a[$], exp_d[$];
  logic [7:0]  got_s[$], exp_s[$];

  always #4 clk = ~clk;

  s2d_wr_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en),
    .desc_valid_i(dv), .desc_ready_o(dr),
    .desc_dst_i(d_dst), .desc_len_i(d_len), .desc_wb_i(d_wb),
    .s_tvalid_i(tv), .s_tready_o(tr), .s_tdata_i(td), .s_tkeep_i(tk), .s_tlast_i(tl),
    .wr_valid_o(wv), .wr_ready_i(wrdy), .wr_addr_o(wa), .wr_data_o(wd), .wr_strb_o(ws),
    .err_len_o(el), .err_wb_o(ew)
  );

  always @(negedge clk) begin
    if (rst_n && wv && wrdy) begin
      got_a.push_back(wa);
      got_d.push_back(wd);
      got_s.push_back(ws);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] data_of(input int id);
    return {32'(id), ~32'(id)};
  endfunction

  task automatic exp_w(input logic [63:0] a, input logic [63:0] d, input logic [7:0] s);
    exp_a.push_back(a); exp_d.push_back(d); exp_s.push_back(s);
  endtask

  // expected writes for one buffer: data beats then record
  task automatic exp_buf(input logic [63:0] dst, input int first_id, input int n,
                         input logic [7:0] lastkeep, input bit eop, input logic [63:0] wb);
    int cnt = 0;
    for (int b = 0; b < n; b++) begin
      logic [7:0] k = (b == n - 1 && eop) ? lastkeep : 8'hFF;
      exp_w(dst + 64'(8 * b), data_of(first_id + b), k);
      cnt += $countones(k);
    end
    exp_w(wb, {32'd0, 16'h52b4, 15'd0, eop}, 8'h0F);
    exp_w(wb + 64'd4, 64'(cnt), 8'h0F);
  endtask

  task automatic cmp(input string req);
    repeat (30) @(posedge clk);
    #2;
    chk(got_a.size() == exp_a.size(), req, "write count", 64'(got_a.size()), 64'(exp_a.size()));
    for (int i = 0; i < exp_a.size() && i < got_a.size(); i++) begin
      chk(got_a[i] == exp_a[i], req, $sformatf("addr #%0d", i), got_a[i], exp_a[i]);
      chk(got_d[i] == exp_d[i], req, $sformatf("data #%0d", i), got_d[i], exp_d[i]);
      chk(got_s[i] == exp_s[i], req, $sformatf("strb #%0d", i), 64'(got_s[i]), 64'(exp_s[i]));
    end
    got_a.delete(); got_d.delete(); got_s.delete();
    exp_a.delete(); exp_d.delete(); exp_s.delete();
  endtask

  task automatic put_desc(input logic [63:0] dst, input logic [31:0] len, input logic [63:0] wb);
    dv = 1'b1; d_dst = dst; d_len = len; d_wb = wb;
    do @(negedge clk); while (!dr);
    @(posedge clk); #2;
    dv = 1'b0;
  endtask

  task automatic send(input int n, input logic [7:0] lastkeep);
    for (int b = 0; b < n; b++) begin
      tv = 1'b1; td = data_of(beat_id);
      tk = (b == n - 1) ? lastkeep : 8'hFF;
      tl = (b == n - 1);
      do @(negedge clk); while (!tr);
      @(posedge clk); #2;
      beat_id++;
    end
    tv = 1'b0; tl = 1'b0;
  endtask

  task automatic cycle_enable();
    en = 1'b0; @(posedge clk); #2;
    en = 1'b1; @(posedge clk); #2;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tr == 1'b0, "R11", "tready", 64'(tr), 0);
    chk(wv == 1'b0, "R11", "wr_valid", 64'(wv), 0);
    chk(dr == 1'b1, "R11", "desc_ready", 64'(dr), 1);
    chk(el == 1'b0 && ew == 1'b0, "R11", "err flags", {62'd0, el, ew}, 0);
  endtask

  task automatic t_enable_gate_and_short();
    int id0;
    put_desc(64'h1000, 32'd64, 64'h8000);
    tv = 1'b1; tk = 8'hFF;
    @(negedge clk);
    chk(tr == 1'b0, "R1", "tready while disabled", 64'(tr), 0);
    @(posedge clk); #2;
    tv = 1'b0;
    en = 1'b1;
    @(negedge clk);
    chk(tr == 1'b1, "R1", "tready once enabled", 64'(tr), 1);
    @(posedge clk); #2;
    id0 = beat_id;
    send(3, 8'h0F);
    exp_buf(64'h1000, id0, 3, 8'h0F, 1'b1, 64'h8000);
    cmp("R4_R6");
  endtask

  task automatic t_exact_fill();
    int id0;
    put_desc(64'h2000, 32'd64, 64'h9000);
    id0 = beat_id;
    send(8, 8'hFF);
    exp_buf(64'h2000, id0, 8, 8'hFF, 1'b1, 64'h9000);
    cmp("R3");
    tv = 1'b1;
    @(negedge clk);
    chk(tr == 1'b0, "R3", "tready after exact fill, no follow-on", 64'(tr), 0);
    @(posedge clk); #2;
    tv = 1'b0;
  endtask

  task automatic t_span();
    int id0;
    put_desc(64'h3000, 32'd64, 64'hA000);
    put_desc(64'h4000, 32'd128, 64'hA010);
    id0 = beat_id;
    send(10, 8'h07);
    exp_buf(64'h3000, id0, 8, 8'hFF, 1'b0, 64'hA000);
    exp_buf(64'h4000, id0 + 8, 2, 8'h07, 1'b1, 64'hA010);
    cmp("R2_R5");
  endtask

  task automatic t_backpressure();
    int id0;
    logic [7:0] lfsr = 8'h5A;
    put_desc(64'h5000, 32'd64, 64'hB000);
    put_desc(64'h6000, 32'd64, 64'hBFF8);
    id0 = beat_id;
    fork
      begin
        repeat (60) begin
          @(posedge clk); #2;
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          wrdy = lfsr[0];
        end
        wrdy = 1'b1;
      end
    join_none
    send(4, 8'h01);
    send(8, 8'hFF);
    exp_buf(64'h5000, id0, 4, 8'h01, 1'b1, 64'hB000);
    exp_buf(64'h6000, id0 + 4, 8, 8'hFF, 1'b1, 64'hBFF8);
    repeat (70) @(posedge clk);
    #2;
    cmp("R10_R8");
  endtask

  task automatic t_bad_len();
    int id0;
    put_desc(64'h7100, 32'd96, 64'hC100);
    chk(el == 1'b1, "R7", "err_len after len 96", 64'(el), 1);
    chk(ew == 1'b0, "R7", "err_wb stays clear", 64'(ew), 0);
    put_desc(64'h7000, 32'd64, 64'hC000);
    tv = 1'b1; tk = 8'hFF; tl = 1'b1; td = data_of(beat_id);
    @(negedge clk);
    chk(tr == 1'b0, "R9", "tready halted by error", 64'(tr), 0);
    @(posedge clk); #2;
    tv = 1'b0; tl = 1'b0;
    cycle_enable();
    chk(el == 1'b0, "R9", "err_len cleared by enable cycle", 64'(el), 0);
    id0 = beat_id;
    send(1, 8'hFF);
    exp_buf(64'h7000, id0, 1, 8'hFF, 1'b1, 64'hC000);
    cmp("R7");
    put_desc(64'h7300, 32'd0, 64'hC300);
    chk(el == 1'b1, "R7", "err_len after len 0", 64'(el), 1);
    cycle_enable();
  endtask

  task automatic t_bad_wb();
    put_desc(64'h7200, 32'd64, 64'hCFFC);
    chk(ew == 1'b1, "R8", "err_wb for 0xFFC", 64'(ew), 1);
    chk(el == 1'b0, "R8", "err_len clear", 64'(el), 0);
    cycle_enable();
    chk(ew == 1'b0, "R9", "err_wb cleared", 64'(ew), 0);
    tv = 1'b1;
    @(negedge clk);
    chk(tr == 1'b0, "R8", "bad descriptor dropped, queue empty", 64'(tr), 0);
    @(posedge clk); #2;
    tv = 1'b0;
    cmp("R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    @(posedge clk); #2;
    t_enable_gate_and_short();
    t_exact_fill();
    t_span();
    t_backpressure();
    t_bad_len();
    t_bad_wb();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule